// File: doc/BRIEF.md
# Drum Phase Error Counter with Two-Write Preset

This block measures the phase of a rotating-drum servo signal against a reference. A 20-bit up-counter reloads from a committed preset on every reference event. It then advances on a count-enable strobe, which comes from an external clock-source selector. On every capture event the block latches the current count as a phase error.

The error is re-referenced so that the counter midpoint (0x80000) reads as zero. Software picks the preset so that the counter reaches the midpoint at the capture instant when the phase is exact. Any deviation then appears directly as a two's-complement-style error around zero.

The preset is written through two write-only word registers. The upper register stages the top 4 bits. A write to the lower register commits all 20 bits at once, so the counter never reloads from a half-updated value. A standby input returns the preset registers to their reset values. Reads of the preset registers return zero. The captured error can be read back as two 16-bit halves.

Top module: `phase_err_counter`

## Requirements
- R1: After reset, the committed preset and the staged upper bits are 0, the counter is 0, err_data is 0, err_vld is 0 and rd_data is 0.
- R2: A full-word write with wr_sel=0 stores wr_data[3:0] as staged upper bits and leaves the committed preset unchanged.
- R3: A full-word write with wr_sel=1 commits {staged upper bits, wr_data[15:0]} as the 20-bit preset at that clock edge.
- R4: A lower write that is not preceded by a new upper write reuses the currently staged upper bits.
- R5: A write with wr_be other than 2'b11 (one bit per byte) is ignored by both registers.
- R6: rd_data is registered with one cycle of latency. rd_sel 0 or 1 (the preset registers) reads 0, rd_sel 2 reads {12'b0, err_data[19:16]} and rd_sel 3 reads err_data[15:0].
- R7: While standby is high, the staged bits and the committed preset are forced to 0 and writes are ignored.
- R8: A ref_evt pulse loads the counter with the committed preset at the next clock edge, and it takes priority over cnt_en.
- R9: With cnt_en high and no ref_evt, the counter increments by one, wrapping modulo 2^20. With neither input, it holds its value.
- R10: A cap_evt pulse sets err_data to (count - 0x80000) mod 2^20 at the next edge, and err_vld is high for exactly that one following cycle.
- R11: When ref_evt and cap_evt coincide, the captured error uses the count from before the reload.
- R12: When a lower-register commit and ref_evt fall on the same edge, the counter loads the previously committed preset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby | input | 1 | Forces the preset registers to their reset values |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = upper preset bits, 1 = lower half and commit |
| wr_data | input | 16 | Write data |
| wr_be | input | 2 | Byte strobes; only 2'b11 is accepted |
| rd_sel | input | 2 | Read select |
| rd_data | output | 16 | Registered read data |
| ref_evt | input | 1 | Reference event; reloads the counter |
| cnt_en | input | 1 | Count enable from the selected clock source |
| cap_evt | input | 1 | Capture event; latches the error |
| err_data | output | 20 | Captured error relative to the midpoint |
| err_vld | output | 1 | One-cycle pulse after each capture |

## Verification
The preset is observable only through the counter. Every check therefore follows the same path: a reload, an optional run of count enables, then a capture. The error that comes out identifies the committed preset one cycle after the capture.

Three kinds of internal fault show up within two clocks as a wrong err_data value on the next capture:
- a staged nibble that was lost, or committed too early;
- a byte-strobed write that slipped through;
- a wrong subtraction reference.

Faults in ordering, such as reload versus capture on one edge or commit versus reload on one edge, show up as the old-versus-new preset difference on that same capture.

// File: rtl/pec_pkg.sv
package pec_pkg;
  typedef enum logic {
    PSEL_UPPER = 1'b0,
    PSEL_LOWER = 1'b1
  } preset_sel_e;

  typedef enum logic [1:0] {
    RSEL_UPPER  = 2'd0,
    RSEL_LOWER  = 2'd1,
    RSEL_ERR_HI = 2'd2,
    RSEL_ERR_LO = 2'd3
  } rd_sel_e;
endpackage

// File: rtl/pec_preset_regs.sv
module pec_preset_regs
  import pec_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W/8-1:0] wr_be,
  output logic [CNT_W-1:0]  preset_q
);
  localparam int HI_W = CNT_W - DATA_W;

  logic [HI_W-1:0] stage_q;
  logic            full_word;
  logic            wr_ok;

  // Only whole-word accesses are honoured; partial strobes are dropped.
  assign full_word = &wr_be;
  assign wr_ok     = wr_en & full_word & ~standby;

  always_ff @(posedge clk) begin
    if (rst || standby) begin
      stage_q  <= '0;
      preset_q <= '0;
    end else if (wr_ok) begin
      if (preset_sel_e'(wr_sel) == PSEL_UPPER) begin
        stage_q <= wr_data[HI_W-1:0];
      end else begin
        preset_q <= {stage_q, wr_data};
      end
    end
  end
endmodule

// File: rtl/pec_counter.sv
module pec_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_evt,
  input  logic             cnt_en,
  input  logic [CNT_W-1:0] preset,
  output logic [CNT_W-1:0] cnt_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ref_evt) begin
      cnt_q <= preset;
    end else if (cnt_en) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pec_capture.sv
module pec_capture #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cap_evt,
  input  logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] err_q,
  output logic             err_vld_q
);
  localparam logic [CNT_W-1:0] MID = {1'b1, {(CNT_W-1){1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      err_q     <= '0;
      err_vld_q <= 1'b0;
    end else begin
      err_vld_q <= cap_evt;
      if (cap_evt) begin
        err_q <= cnt - MID;
      end
    end
  end
endmodule

// File: rtl/phase_err_counter.sv
module phase_err_counter
  import pec_pkg::*;
#(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              standby,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W/8-1:0] wr_be,
  input  logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] rd_data,
  input  logic              ref_evt,
  input  logic              cnt_en,
  input  logic              cap_evt,
  output logic [CNT_W-1:0]  err_data,
  output logic              err_vld
);
  logic [CNT_W-1:0] preset_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] err_hi_shift;

  pec_preset_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .standby  (standby),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .wr_be    (wr_be),
    .preset_q (preset_q)
  );

  pec_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .ref_evt (ref_evt),
    .cnt_en  (cnt_en),
    .preset  (preset_q),
    .cnt_q   (cnt_q)
  );

  pec_capture #(.CNT_W(CNT_W)) u_cap (
    .clk       (clk),
    .rst       (rst),
    .cap_evt   (cap_evt),
    .cnt       (cnt_q),
    .err_q     (err_data),
    .err_vld_q (err_vld)
  );

  assign err_hi_shift = err_data >> DATA_W;

  // Registered readback; the preset registers are write-only and read zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_sel_e'(rd_sel))
        RSEL_ERR_HI: rd_data <= err_hi_shift[DATA_W-1:0];
        RSEL_ERR_LO: rd_data <= err_data[DATA_W-1:0];
        default:     rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pec_chk.sv
module pec_chk #(
  parameter int CNT_W  = 20,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              standby,
  input logic              wr_en,
  input logic [DATA_W/8-1:0] wr_be,
  input logic [1:0]        rd_sel,
  input logic [DATA_W-1:0] rd_data,
  input logic              ref_evt,
  input logic              cnt_en,
  input logic              cap_evt,
  input logic [CNT_W-1:0]  err_data,
  input logic              err_vld,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  preset
);
  localparam logic [CNT_W-1:0] MID = {1'b1, {(CNT_W-1){1'b0}}};

  // R5
  partial_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !(&wr_be) && !standby) |=> $stable(preset));

  // R6
  preset_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel[1] == 1'b0) |=> (rd_data == '0));

  // R7
  standby_clear_chk: assert property (@(posedge clk) disable iff (rst)
    standby |=> (preset == '0));

  // R8
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    ref_evt |=> (cnt == $past(preset)));

  // R9
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!ref_evt && cnt_en) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));

  // R9
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ref_evt && !cnt_en) |=> $stable(cnt));

  // R10
  capture_value_chk: assert property (@(posedge clk) disable iff (rst)
    cap_evt |=> (err_data == CNT_W'($past(cnt) - MID)));

  // R10
  valid_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    !cap_evt |=> !err_vld);
endmodule

bind phase_err_counter pec_chk #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .standby  (standby),
  .wr_en    (wr_en),
  .wr_be    (wr_be),
  .rd_sel   (rd_sel),
  .rd_data  (rd_data),
  .ref_evt  (ref_evt),
  .cnt_en   (cnt_en),
  .cap_evt  (cap_evt),
  .err_data (err_data),
  .err_vld  (err_vld),
  .cnt      (cnt_q),
  .preset   (preset_q)
);

// File: tb/phase_err_counter_tb.sv
`timescale 1ns/1ps
module phase_err_counter_tb;
  localparam logic [19:0] MID = 20'h80000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        standby = 1'b0;
  logic        wr_en = 1'b0;
  logic        wr_sel = 1'b0;
  logic [15:0] wr_data = '0;
  logic [1:0]  wr_be = '0;
  logic [1:0]  rd_sel = 2'd0;
  logic [15:0] rd_data;
  logic        ref_evt = 1'b0;
  logic        cnt_en = 1'b0;
  logic        cap_evt = 1'b0;
  logic [19:0] err_data;
  logic        err_vld;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  phase_err_counter u_dut (
    .clk(clk), .rst(rst), .standby(standby), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .wr_be(wr_be), .rd_sel(rd_sel), .rd_data(rd_data),
    .ref_evt(ref_evt), .cnt_en(cnt_en), .cap_evt(cap_evt),
    .err_data(err_data), .err_vld(err_vld)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic sel, input logic [15:0] d, input logic [1:0] be);
    wr_en = 1'b1; wr_sel = sel; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 2'b00;
  endtask

  task automatic do_ref();
    ref_evt = 1'b1;
    @(negedge clk);
    ref_evt = 1'b0;
  endtask

  task automatic count(input int n);
    cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic cap_chk(input logic [19:0] cnt_exp, input string req);
    cap_evt = 1'b1;
    @(negedge clk);
    cap_evt = 1'b0;
    check(err_data == cnt_exp - MID, req, 32'(err_data), 32'(cnt_exp - MID));
    check(err_vld == 1'b1, {req, " vld"}, 32'(err_vld), 32'd1);
    @(negedge clk);
    check(err_vld == 1'b0, {req, " vld pulse"}, 32'(err_vld), 32'd0);
  endtask

  task automatic probe(input logic [19:0] p, input string req);
    do_ref();
    cap_chk(p, req);
  endtask

  task automatic t_reset();
    check(err_data == '0, "R1 err", 32'(err_data), 0);
    check(err_vld == 1'b0, "R1 vld", 32'(err_vld), 0);
    check(rd_data == '0, "R1 rd", 32'(rd_data), 0);
    cap_chk(20'h00000, "R1 count");
    probe(20'h00000, "R1 preset");
  endtask

  task automatic t_two_write();
    do_wr(1'b0, 16'h000A, 2'b11);
    probe(20'h00000, "R2 staged only");
    do_wr(1'b1, 16'h1234, 2'b11);
    probe(20'hA1234, "R3 commit");
    do_wr(1'b1, 16'h0042, 2'b11);
    probe(20'hA0042, "R4 reuse upper");
  endtask

  task automatic t_partial();
    do_wr(1'b1, 16'hFFFF, 2'b01);
    probe(20'hA0042, "R5 lower byte");
    do_wr(1'b0, 16'h0005, 2'b10);
    do_wr(1'b1, 16'h0001, 2'b11);
    probe(20'hA0001, "R5 upper byte");
  endtask

  task automatic t_read();
    logic [19:0] e;
    e = 20'hA0001 - MID;
    rd_sel = 2'd2; @(negedge clk);
    check(rd_data == {12'h000, e[19:16]}, "R6 err hi", 32'(rd_data), 32'(e[19:16]));
    rd_sel = 2'd3; @(negedge clk);
    check(rd_data == e[15:0], "R6 err lo", 32'(rd_data), 32'(e[15:0]));
    rd_sel = 2'd0; @(negedge clk);
    check(rd_data == '0, "R6 upper reads 0", 32'(rd_data), 0);
    rd_sel = 2'd1; @(negedge clk);
    check(rd_data == '0, "R6 lower reads 0", 32'(rd_data), 0);
    rd_sel = 2'd0;
  endtask

  task automatic t_standby();
    do_wr(1'b0, 16'h0003, 2'b11);
    do_wr(1'b1, 16'h3333, 2'b11);
    standby = 1'b1;
    do_wr(1'b1, 16'h7777, 2'b11);
    standby = 1'b0;
    probe(20'h00000, "R7 standby clear");
    do_wr(1'b1, 16'h0010, 2'b11);
    probe(20'h00010, "R7 staged cleared");
  endtask

  task automatic t_count();
    do_wr(1'b0, 16'h0007, 2'b11);
    do_wr(1'b1, 16'hFF00, 2'b11);
    do_ref();
    count(16);
    cap_chk(20'h7FF10, "R9 count");
    @(negedge clk);
    cap_chk(20'h7FF10, "R9 hold");
    ref_evt = 1'b1; cnt_en = 1'b1;
    @(negedge clk);
    ref_evt = 1'b0; cnt_en = 1'b0;
    cap_chk(20'h7FF00, "R8 priority");
    do_wr(1'b0, 16'h000F, 2'b11);
    do_wr(1'b1, 16'hFFFE, 2'b11);
    do_ref();
    count(3);
    cap_chk(20'h00001, "R9 wrap");
  endtask

  task automatic t_coincide();
    do_wr(1'b0, 16'h0001, 2'b11);
    do_wr(1'b1, 16'h0000, 2'b11);
    do_ref();
    count(5);
    do_wr(1'b0, 16'h0002, 2'b11);
    do_wr(1'b1, 16'h0000, 2'b11);
    ref_evt = 1'b1;
    cap_chk(20'h10005, "R11 pre-reload");
    ref_evt = 1'b0;
    cap_chk(20'h20000, "R11 post-reload");
    do_wr(1'b0, 16'h0003, 2'b11);
    ref_evt = 1'b1;
    do_wr(1'b1, 16'h0000, 2'b11);
    ref_evt = 1'b0;
    cap_chk(20'h20000, "R12 old preset");
    probe(20'h30000, "R12 new preset");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_two_write();
    t_partial();
    t_read();
    t_standby();
    t_count();
    t_coincide();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule